// File: doc/BRIEF.md
# Configuration Image Stream Loader

The loader accepts a static configuration image delivered as 32-bit words on a simple memory-mapped write port, typically fed by a serial slave front end. A load begins with a write to a fixed base address. The word in that write must equal the device identifier. If it matches, the loader unlocks and parses the words that follow. Each block is a block ID word, a length word, a header CRC word, the payload words and a payload CRC word. A block of length zero ends the image and is followed by one global CRC word.

Words after the identifier may arrive in any number of bursts, cut at any word boundary, at any address other than the base, with idle gaps between bursts. The loader checks only the CRCs, never the meaning of the payload, and it stores no table contents. The result of each load attempt is published in a readable status word. That word changes only when an attempt ends.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset the status word reads 0x0000_0000.
- R2: A write to the base address carrying the device identifier unlocks parsing and leaves the status word unchanged.
- R3: A write to the base address with any other value ends the attempt at once. The status word then shows bit 29 = 1 and bits 31, 30 and 28 = 0. All following non-base writes are ignored until the next base write.
- R4: A write to the base address always abandons any load in progress and starts a new one. An abandoned load does not advance the slot counter.
- R5: Stream words may use any non-base address and may be separated by any number of idle cycles. Parser state is kept across those gaps.
- R6: The CRC is CRC-32: reflected polynomial 0xEDB88320, initial value 0xFFFF_FFFF, final inversion. Each word is fed bit 0 first. The header CRC covers the ID and length words. The payload CRC covers the payload words. The length is the low 16 bits of the length word.
- R7: A block with length zero ends the image. The next word is the global CRC. It covers every word after the identifier, up to and including the terminating block's header CRC word.
- R8: After an error-free load, bit 31 is 1 and bits 30, 29 and 28 are 0.
- R9: If any header or payload CRC mismatches, bit 30 is set and bit 31 stays clear when the image ends.
- R10: A global CRC mismatch sets bit 28 and keeps bit 31 clear.
- R11: Bits 3:0 count completed attempts, each good, failed or ID-rejected. The count increments by one per attempt and wraps from 15 to 0.
- R12: While an image is being received, the status word keeps the result of the previous attempt.
- R13: After an image ends, the loader locks again and ignores non-base writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one word per cycle |
| wrAddr | input | ADDR_W (20) | Word address of the write |
| wrData | input | 32 | Written word |
| statusWord | output | 32 | Load result: bit 31 loaded, bit 30 local CRC error, bit 29 ID error, bit 28 global CRC error, bits 3:0 attempt count |

## Verification
The embedded assertions check several properties on every cycle:
- A locked or rejected loader stays put under non-base writes.
- A base write always lands in a fresh start or a rejection.
- Idle cycles freeze the parser.
- The status word moves only on an end-of-attempt strobe, and then the count steps by exactly one.
- A loaded flag never coexists with an error flag.

Only the bench scenarios can show that the CRC definition, the coverage of the global CRC, the block framing and the parsing across segmented deliveries produce the right verdict for whole images. Those scenarios compare the status word each clock against a queue-based model.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_LOCKED,
    ST_REJECT,
    ST_BLKID,
    ST_BLKLEN,
    ST_HDRCRC,
    ST_PAYLOAD,
    ST_PAYCRC,
    ST_GLOBCRC
  } loadState_e;

  // strobes from control to datapath, at most a few per cycle
  typedef struct packed {
    logic restart;   // good identifier seen
    logic hdrFirst;  // block ID word
    logic hdrNext;   // length word
    logic payFirst;  // first payload word
    logic payNext;   // later payload word
    logic globUpd;   // word belongs to global CRC
    logic chkHdr;    // header CRC word present
    logic chkPay;    // payload CRC word present
    logic finish;    // global CRC word present, commit verdict
    logic idFail;    // identifier mismatch, commit rejection
  } ldStrobe_t;

  // one 32-bit word through a reflected CRC-32, bit 0 first
  function automatic logic [31:0] crcStep(input logic [31:0] crcIn,
                                          input logic [31:0] word);
    logic [31:0] c;
    logic        fb;
    c = crcIn;
    for (int i = 0; i < 32; i++) begin
      fb = c[0] ^ word[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             isBase,
  input  logic             idMatch,
  input  logic [LEN_W-1:0] lenIn,
  output ldStrobe_t        strobe
);

  loadState_e       state, nextState;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] cntQ;
  logic             lastPay;

  assign lastPay = (cntQ == lenQ - 1'b1);

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (wrEn) begin
      if (isBase) begin
        if (idMatch) begin
          strobe.restart = 1'b1;
          nextState      = ST_BLKID;
        end else begin
          strobe.idFail = 1'b1;
          nextState     = ST_REJECT;
        end
      end else begin
        unique case (state)
          ST_BLKID: begin
            strobe.hdrFirst = 1'b1;
            strobe.globUpd  = 1'b1;
            nextState       = ST_BLKLEN;
          end
          ST_BLKLEN: begin
            strobe.hdrNext = 1'b1;
            strobe.globUpd = 1'b1;
            nextState      = ST_HDRCRC;
          end
          ST_HDRCRC: begin
            strobe.chkHdr  = 1'b1;
            strobe.globUpd = 1'b1;
            nextState      = (lenQ == '0) ? ST_GLOBCRC : ST_PAYLOAD;
          end
          ST_PAYLOAD: begin
            strobe.payFirst = (cntQ == '0);
            strobe.payNext  = (cntQ != '0);
            strobe.globUpd  = 1'b1;
            if (lastPay) nextState = ST_PAYCRC;
          end
          ST_PAYCRC: begin
            strobe.chkPay  = 1'b1;
            strobe.globUpd = 1'b1;
            nextState      = ST_BLKID;
          end
          ST_GLOBCRC: begin
            strobe.finish = 1'b1;
            nextState     = ST_LOCKED;
          end
          default: nextState = state;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOCKED;
      lenQ  <= '0;
      cntQ  <= '0;
    end else begin
      state <= nextState;
      if (wrEn && !isBase) begin
        if (state == ST_BLKLEN) lenQ <= lenIn;
        if (state == ST_HDRCRC) cntQ <= '0;
        if (state == ST_PAYLOAD) cntQ <= cntQ + 1'b1;
      end
    end
  end

  // R13: a locked loader ignores non-base writes
  assert_locked_ignores_R13: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && wrEn && !isBase) |=> state == ST_LOCKED);

  // R3: a rejected load stays rejected until a base write
  assert_reject_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REJECT && !(wrEn && isBase)) |=> state == ST_REJECT);

  // R4: any base write starts over or rejects
  assert_base_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isBase) |=> (state == ST_BLKID || state == ST_REJECT));

  // R5: idle gaps keep parser state
  assert_gap_keeps_state_R5: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(state) && $stable(cntQ) && $stable(lenQ)));

endmodule

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter logic [31:0] DEVICE_ID = 32'hC0DE_0117,
  parameter int          SLOT_W    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] wrData,
  input  ldStrobe_t   strobe,
  output logic        idMatch,
  output logic [31:0] statusWord
);

  localparam int PAD_W = 28 - SLOT_W;

  logic [31:0]       hdrCrc, payCrc, globCrc;
  logic              localErr;
  logic              loadedQ, locErrQ, idErrQ, globErrQ;
  logic [SLOT_W-1:0] slotQ;
  logic              globOk;

  assign idMatch    = (wrData == DEVICE_ID);
  assign globOk     = (wrData == ~globCrc);
  assign statusWord = {loadedQ, locErrQ, idErrQ, globErrQ, {PAD_W{1'b0}}, slotQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrCrc   <= CRC_SEED;
      payCrc   <= CRC_SEED;
      globCrc  <= CRC_SEED;
      localErr <= 1'b0;
      loadedQ  <= 1'b0;
      locErrQ  <= 1'b0;
      idErrQ   <= 1'b0;
      globErrQ <= 1'b0;
      slotQ    <= '0;
    end else begin
      if (strobe.restart) begin
        globCrc  <= CRC_SEED;
        localErr <= 1'b0;
      end
      if (strobe.hdrFirst) hdrCrc <= crcStep(CRC_SEED, wrData);
      if (strobe.hdrNext)  hdrCrc <= crcStep(hdrCrc, wrData);
      if (strobe.payFirst) payCrc <= crcStep(CRC_SEED, wrData);
      if (strobe.payNext)  payCrc <= crcStep(payCrc, wrData);
      if (strobe.globUpd)  globCrc <= crcStep(globCrc, wrData);
      if (strobe.chkHdr && (wrData != ~hdrCrc)) localErr <= 1'b1;
      if (strobe.chkPay && (wrData != ~payCrc)) localErr <= 1'b1;
      if (strobe.finish) begin
        loadedQ  <= globOk && !localErr;
        locErrQ  <= localErr;
        idErrQ   <= 1'b0;
        globErrQ <= !globOk;
        slotQ    <= slotQ + 1'b1;
      end
      if (strobe.idFail) begin
        loadedQ  <= 1'b0;
        locErrQ  <= 1'b0;
        idErrQ   <= 1'b1;
        globErrQ <= 1'b0;
        slotQ    <= slotQ + 1'b1;
      end
    end
  end

  // R12: status moves only when an attempt ends
  assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finish || strobe.idFail) |=> $stable(statusWord));

  // R11: one step of the attempt counter per completed attempt
  assert_slot_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish || strobe.idFail) |=> slotQ == $past(slotQ) + 1'b1);

  // R8: loaded never shown together with an error
  assert_loaded_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31] |-> statusWord[30:28] == 3'b000);

  // R3: a cycle ends at most one attempt
  assert_single_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.finish, strobe.idFail}));

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_loader_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h2_0000,
  parameter logic [31:0]     DEVICE_ID = 32'hC0DE_0117,
  parameter int              LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       statusWord
);

  ldStrobe_t strobe;
  logic      isBase;
  logic      idMatch;

  assign isBase = (wrAddr == BASE_ADDR);

  cfg_loader_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .isBase  (isBase),
    .idMatch (idMatch),
    .lenIn   (wrData[LEN_W-1:0]),
    .strobe  (strobe)
  );

  cfg_loader_dp #(.DEVICE_ID(DEVICE_ID), .SLOT_W(4)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .strobe     (strobe),
    .idMatch    (idMatch),
    .statusWord (statusWord)
  );

endmodule

// File: tb/test_cfg_image_loader.sv
`timescale 1ns/1ps
module test_cfg_image_loader;

  localparam bit [19:0] BASE = 20'h2_0000;
  localparam bit [31:0] DEV  = 32'hC0DE_0117;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] statusWord;

  int nCmp = 0;
  int nBad = 0;
  bit running = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int          mPh = 0;   // 0 locked 1 reject 2 id 3 len 4 hcrc 5 pay 6 pcrc 7 glob
  int          mLen, mCnt, mSlot = 0;
  bit          mLocErr;
  bit [31:0]   mStatus = 0;
  bit [31:0]   hq[$], pq[$], gq[$];

  bit [31:0]   img[$];
  int          blkLens[$];

  always #4 clk = ~clk;

  cfg_image_loader i_cfg_image_loader (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .statusWord(statusWord)
  );

  function automatic bit [31:0] crcOf(input bit [31:0] q[$]);
    bit [31:0] c = 32'hFFFF_FFFF;
    foreach (q[k]) begin
      for (int i = 0; i < 32; i++) begin
        bit f = c[0] ^ q[k][i];
        c = {1'b0, c[31:1]};
        if (f) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic modelWrite(input bit [19:0] a, input bit [31:0] d);
    if (a == BASE) begin
      if (d == DEV) begin
        mPh = 2; mLocErr = 0; gq.delete();
      end else begin
        mPh = 1; mSlot = (mSlot + 1) % 16;
        mStatus = {4'b0010, 24'b0, 4'(mSlot)};
      end
    end else begin
      case (mPh)
        2: begin hq.delete(); hq.push_back(d); gq.push_back(d); mPh = 3; end
        3: begin hq.push_back(d); gq.push_back(d); mLen = int'(d[15:0]); mPh = 4; end
        4: begin
          if (d != crcOf(hq)) mLocErr = 1;
          gq.push_back(d); mCnt = 0; pq.delete();
          mPh = (mLen == 0) ? 7 : 5;
        end
        5: begin
          pq.push_back(d); gq.push_back(d); mCnt++;
          if (mCnt == mLen) mPh = 6;
        end
        6: begin if (d != crcOf(pq)) mLocErr = 1; gq.push_back(d); mPh = 2; end
        7: begin
          bit g = (d == crcOf(gq));
          mSlot = (mSlot + 1) % 16;
          mStatus = {g && !mLocErr, mLocErr, 1'b0, !g, 24'b0, 4'(mSlot)};
          mPh = 0;
        end
        default: ;
      endcase
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (running) begin
      nCmp++;
      if (statusWord !== mStatus) begin
        nBad++;
        $display("FAIL %s per-cycle status: actual %h expected %h", curReq, statusWord, mStatus);
      end
    end
  end

  task automatic chk(input bit [31:0] exp, input string req);
    nCmp++;
    if (statusWord !== exp) begin
      nBad++;
      $display("FAIL %s status: actual %h expected %h", req, statusWord, exp);
    end
  endtask

  task automatic wr(input bit [19:0] a, input bit [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 modelWrite(a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; wrData = 32'hFFFF_0000 + i;
    end
  endtask

  task automatic pushG(input bit [31:0] w, inout bit [31:0] g[$]);
    img.push_back(w); g.push_back(w);
  endtask

  // image of blkLens blocks plus terminator; errors injected by index
  task automatic buildImg(input int badHdr, input int badPay, input bit badGlob);
    bit [31:0] g[$];
    bit [31:0] q[$];
    img.delete();
    img.push_back(DEV);
    for (int b = 0; b <= blkLens.size(); b++) begin
      int len = (b < blkLens.size()) ? blkLens[b] : 0;
      bit [31:0] bid = 32'h0000_0100 + b;
      q.delete(); q.push_back(bid); q.push_back(32'(len));
      pushG(bid, g); pushG(32'(len), g);
      pushG(crcOf(q) ^ ((b == badHdr) ? 32'h1 : 32'h0), g);
      if (len > 0) begin
        q.delete();
        for (int i = 0; i < len; i++) begin
          bit [31:0] w = {bid[15:0], 16'(i)} ^ 32'h5A3C_96E1;
          q.push_back(w); pushG(w, g);
        end
        pushG(crcOf(q) ^ ((b == badPay) ? 32'h8000_0000 : 32'h0), g);
      end
    end
    img.push_back(crcOf(g) ^ (badGlob ? 32'h10 : 32'h0));
  endtask

  // send img from index 'from'; id at base, rest at rising non-base addresses
  task automatic sendImg(input int from, input int chunk, input int gap);
    for (int i = from; i < img.size(); i++) begin
      if (chunk > 0 && i > 1 && ((i - 1) % chunk) == 0) idle(gap);
      wr((i == 0) ? BASE : BASE + 20'(i) + 20'h40, img[i]);
    end
    idle(1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(32'h0, "R1");
    running = 1;

    // R2 R6 R7 R8: good single-burst load
    curReq = "R8";
    blkLens.delete(); blkLens.push_back(3); blkLens.push_back(1);
    buildImg(-1, -1, 0);
    wr(BASE, DEV);
    chk(32'h0, "R2");
    curReq = "R12";
    sendImg(1, 0, 0);
    chk(32'h8000_0001, "R8");

    // R13: stray writes after the image ends
    curReq = "R13";
    wr(BASE + 20'h5, 32'h0000_0101);
    wr(BASE + 20'h9, 32'h0);
    idle(2);
    chk(32'h8000_0001, "R13");

    // R5: segmented delivery with gaps
    curReq = "R5";
    blkLens.delete(); blkLens.push_back(5); blkLens.push_back(2); blkLens.push_back(1);
    buildImg(-1, -1, 0);
    sendImg(0, 3, 4);
    chk(32'h8000_0002, "R5");

    // R9: bad header CRC, then bad payload CRC
    curReq = "R9";
    buildImg(1, -1, 0);
    sendImg(0, 0, 0);
    chk(32'h4000_0003, "R9");
    buildImg(-1, 0, 0);
    sendImg(0, 2, 1);
    chk(32'h4000_0004, "R9");

    // R10: bad global CRC
    curReq = "R10";
    buildImg(-1, -1, 1);
    sendImg(0, 0, 0);
    chk(32'h1000_0005, "R10");

    // R3: identifier mismatch, later stream ignored
    curReq = "R3";
    buildImg(-1, -1, 0);
    wr(BASE, DEV ^ 32'h4);
    chk(32'h2000_0006, "R3");
    sendImg(1, 0, 0);
    chk(32'h2000_0006, "R3");

    // R4: restart in the middle of a load
    curReq = "R4";
    for (int i = 0; i < 6; i++) wr((i == 0) ? BASE : BASE + 20'(i), img[i]);
    idle(2);
    sendImg(0, 0, 0);
    chk(32'h8000_0007, "R4");

    // R11: counter wrap
    curReq = "R11";
    for (int k = 0; k < 9; k++) wr(BASE, 32'hDEAD_0000 + k);
    idle(1);
    chk(32'h2000_0000, "R11");
    blkLens.delete(); blkLens.push_back(2);
    buildImg(-1, -1, 0);
    sendImg(0, 1, 2);
    chk(32'h8000_0001, "R11");

    idle(3);
    running = 0;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule